// File: doc/BRIEF.md
# Bitplane Pixel Serialiser with Colour Palette

This block turns display data held in interleaved bitplane form into a stream of coloured pixels. A fetch engine hands it 16-bit plane words over a valid/ready handshake, one group at a time. A group is the set of plane words that together describe 16 adjacent pixels. On each pixel-clock enable the block takes the next bit position from every plane word of the current group and forms a colour index from those bits. It looks the index up in a programmable 16-entry palette and drives 3-bit red, green and blue levels. Each level is meant for three on/off lines that an external resistor ladder weights into eight equal steps.

A CPU-side write port programs the palette and a mode register. The mode selects four planes (16 colours), two planes (4 colours) or a single plane. In single-plane mode the palette is bypassed: each bit is one pixel on a dedicated monochrome output, and bit 0 of palette entry 0 selects inverse video. The block holds two groups, the one being shifted out and the next one being filled, so a fetch engine that keeps up produces a gap-free pixel stream. A display-enable input blanks the outputs during retrace.

Top module: `plane_shifter`

## Requirements
- R1: A write with `wr_addr` 0 to 15 stores `wr_data` into that palette entry, with red in bits 8:6, green in bits 5:3 and blue in bits 2:0. A write to address 16 stores `wr_data[1:0]` as the mode: 0 = four planes, 1 = two planes, 2 = one plane. Reset clears every palette entry and selects four planes.
- R2: In four-plane mode, the pixel at bit position b has index {w3[b], w2[b], w1[b], w0[b]}, where w0 is the first word loaded for the group. The RGB outputs show the palette entry at that index and `mono` is 0.
- R3: In two-plane mode a group is two words, the index is {w1[b], w0[b]}, and only palette entries 0 to 3 are reachable.
- R4: In one-plane mode a group is one word. `mono` equals w0[b] XOR bit 0 of palette entry 0, and red, green and blue are all 0.
- R5: Pixels leave in bit order 0, 1, … 15, one per clock with `pix_en` high. Outputs change only on a clock edge where `pix_en` is high and otherwise hold their value.
- R6: `ld_ready` is high while the fill buffer is not full. It falls on the edge that accepts the last word of a group (4, 2 or 1 words, depending on the mode).
- R7: The filled group moves into the shifter on the `pix_en` edge that emits the last pixel of the current group, so the next group follows with no gap. `ld_ready` is high again after that edge.
- R8: A `pix_en` edge with no pixel pending gives black (RGB 0, `mono` 0). If a group is waiting, it is moved in on that edge and its first pixel appears on the next `pix_en` edge.
- R9: With `disp_en` low at a `pix_en` edge, the outputs go to black, and the pixel for that position is still consumed.
- R10: A write to the mode register discards the partly or fully loaded group and any pixels still pending, so `ld_ready` is high after that edge. A mode value of 3 behaves as one-plane mode.
- R11: After reset, red, green, blue and `mono` are 0 and `ld_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel clock enable: one pixel per high cycle |
| disp_en | input | 1 | Display enable; low forces black |
| wr_en | input | 1 | CPU register write strobe |
| wr_addr | input | 5 | 0–15 palette entry, 16 mode register |
| wr_data | input | 9 | Palette colour {r,g,b} or mode in bits 1:0 |
| ld_valid | input | 1 | Plane word offered |
| ld_data | input | 16 | Plane word |
| ld_ready | output | 1 | Fill buffer can accept a word |
| red | output | 3 | Red level |
| green | output | 3 | Green level |
| blue | output | 3 | Blue level |
| mono | output | 1 | Monochrome pixel |

## Verification
Register writes and word loads take effect on the edge that samples them. The colour outputs are registered at the `pix_en` edge that consumes a pixel, so a pixel's colour is visible straight after that edge. Starting from an empty shifter, the first `pix_en` edge only moves the group in, and the first pixel is due one `pix_en` edge later. The bench drives every input on the falling edge and samples one falling edge later, after exactly one rising edge. Its expected sequences count that initial black pixel and the seamless handover at pixel 15, and the expected colours come from the arithmetic palette pattern the bench itself programs.

// File: rtl/plsh_pkg.sv
package plsh_pkg;

    localparam int WORD_W     = 16;
    localparam int MAX_PLANES = 4;
    localparam int CH_W       = 3;
    localparam int PAL_N      = 1 << MAX_PLANES;
    localparam int IDX_W      = MAX_PLANES;
    localparam int ENTRY_W    = 3 * CH_W;
    localparam int ADDR_W     = $clog2(PAL_N) + 1;
    localparam int MODE_ADDR  = PAL_N;
    localparam int PL_W       = $clog2(MAX_PLANES);
    localparam int CNT_W      = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        MODE_P4  = 2'd0,
        MODE_P2  = 2'd1,
        MODE_P1  = 2'd2,
        MODE_P1B = 2'd3
    } mode_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } colour_t;

    // index of the final plane word of a group
    function automatic logic [PL_W-1:0] last_plane(mode_e m);
        case (m)
            MODE_P4: return PL_W'(MAX_PLANES - 1);
            MODE_P2: return PL_W'(1);
            default: return '0;
        endcase
    endfunction

    // planes that contribute to the palette index
    function automatic logic [IDX_W-1:0] index_mask(mode_e m);
        case (m)
            MODE_P4: return '1;
            MODE_P2: return IDX_W'(3);
            default: return IDX_W'(1);
        endcase
    endfunction

    function automatic logic is_mono(mode_e m);
        return (m == MODE_P1) || (m == MODE_P1B);
    endfunction

endpackage

// File: rtl/plsh_regs.sv
module plsh_regs
    import plsh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [ENTRY_W-1:0]   wr_data,
    output colour_t              pal [PAL_N],
    output mode_e                mode,
    output logic                 mode_wr
);

    logic pal_hit;

    assign pal_hit = wr_en && (wr_addr < ADDR_W'(PAL_N));
    assign mode_wr = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAL_N; i++) begin
                pal[i] <= '0;
            end
            mode <= MODE_P4;
        end else begin
            if (pal_hit) begin
                pal[wr_addr[IDX_W-1:0]] <= colour_t'(wr_data);
            end
            if (mode_wr) begin
                mode <= mode_e'(wr_data[1:0]);
            end
        end
    end

    AST_MODE_STORED: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode == mode_e'($past(wr_data[1:0])))); // R1

endmodule

// File: rtl/plsh_loader.sv
module plsh_loader
    import plsh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  mode_e                mode,
    input  logic                 ld_valid,
    input  logic [WORD_W-1:0]    ld_data,
    input  logic                 take,
    output logic                 ld_ready,
    output logic                 full,
    output logic [WORD_W-1:0]    words [MAX_PLANES]
);

    logic [PL_W-1:0] wcnt;
    logic            accept;
    logic            last_word;

    assign ld_ready  = !full;
    assign accept    = ld_valid && !full;
    assign last_word = (wcnt == last_plane(mode));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            full <= 1'b0;
            wcnt <= '0;
            for (int p = 0; p < MAX_PLANES; p++) begin
                words[p] <= '0;
            end
        end else begin
            if (take) begin
                full <= 1'b0;
            end
            if (accept) begin
                words[wcnt] <= ld_data;
                if (last_word) begin
                    full <= 1'b1;
                    wcnt <= '0;
                end else begin
                    wcnt <= wcnt + PL_W'(1);
                end
            end
        end
    end

    AST_GROUP_FULL: assert property (@(posedge clk) disable iff (rst)
        (accept && last_word && !clr) |=> !ld_ready); // R6

    AST_TAKE_FREES: assert property (@(posedge clk) disable iff (rst)
        (take && !clr) |=> ld_ready); // R7

endmodule

// File: rtl/plsh_serial.sv
module plsh_serial
    import plsh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 pix_en,
    input  logic                 full,
    input  logic [WORD_W-1:0]    words [MAX_PLANES],
    output logic                 take,
    output logic [MAX_PLANES-1:0] cur_bits,
    output logic                 cur_valid
);

    logic [CNT_W-1:0] cnt;

    assign cur_valid = (cnt != '0);
    assign take      = pix_en && full && (cnt <= CNT_W'(1));

    for (genvar p = 0; p < MAX_PLANES; p++) begin : g_plane
        logic [WORD_W-1:0] sh;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                sh <= '0;
            end else if (take) begin
                sh <= words[p];
            end else if (pix_en && cur_valid) begin
                sh <= sh >> 1;
            end
        end

        assign cur_bits[p] = sh[0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= CNT_W'(WORD_W);
        end else if (pix_en && cur_valid) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W)); // R5

    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (rst)
        (take && !clr) |=> (cnt == CNT_W'(WORD_W))); // R7

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !take && !clr && cur_valid) |=> (cnt == $past(cnt) - CNT_W'(1))); // R5

endmodule

// File: rtl/plsh_colour.sv
module plsh_colour
    import plsh_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pix_en,
    input  logic                  disp_en,
    input  mode_e                 mode,
    input  colour_t               pal [PAL_N],
    input  logic [MAX_PLANES-1:0] cur_bits,
    input  logic                  cur_valid,
    output colour_t               rgb_q,
    output logic                  mono_q
);

    logic [IDX_W-1:0] idx;
    logic             show;
    logic             mono_mode;

    assign idx       = cur_bits & index_mask(mode);
    assign show      = disp_en && cur_valid;
    assign mono_mode = is_mono(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb_q  <= '0;
            mono_q <= 1'b0;
        end else if (pix_en) begin
            if (!show) begin
                rgb_q  <= '0;
                mono_q <= 1'b0;
            end else if (mono_mode) begin
                rgb_q  <= '0;
                mono_q <= cur_bits[0] ^ pal[0].b[0];
            end else begin
                rgb_q  <= pal[idx];
                mono_q <= 1'b0;
            end
        end
    end

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !disp_en) |=> ((rgb_q == '0) && !mono_q)); // R9

    AST_MONO_NO_RGB: assert property (@(posedge clk) disable iff (rst)
        (pix_en && mono_mode) |=> (rgb_q == '0)); // R4

    AST_COLOUR_NO_MONO: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !mono_mode) |=> !mono_q); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(rgb_q) && $stable(mono_q))); // R5

    AST_UNDERRUN_BLACK: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !cur_valid) |=> ((rgb_q == '0) && !mono_q)); // R8

endmodule

// File: rtl/plane_shifter.sv
module plane_shifter
    import plsh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pix_en,
    input  logic                 disp_en,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [ENTRY_W-1:0]   wr_data,
    input  logic                 ld_valid,
    input  logic [WORD_W-1:0]    ld_data,
    output logic                 ld_ready,
    output logic [CH_W-1:0]      red,
    output logic [CH_W-1:0]      green,
    output logic [CH_W-1:0]      blue,
    output logic                 mono
);

    colour_t               pal [PAL_N];
    mode_e                 mode;
    logic                  mode_wr;
    logic                  full;
    logic                  take;
    logic [WORD_W-1:0]     words [MAX_PLANES];
    logic [MAX_PLANES-1:0] cur_bits;
    logic                  cur_valid;
    colour_t               rgb_q;

    plsh_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pal     (pal),
        .mode    (mode),
        .mode_wr (mode_wr)
    );

    plsh_loader u_loader (
        .clk      (clk),
        .rst      (rst),
        .clr      (mode_wr),
        .mode     (mode),
        .ld_valid (ld_valid),
        .ld_data  (ld_data),
        .take     (take),
        .ld_ready (ld_ready),
        .full     (full),
        .words    (words)
    );

    plsh_serial u_serial (
        .clk       (clk),
        .rst       (rst),
        .clr       (mode_wr),
        .pix_en    (pix_en),
        .full      (full),
        .words     (words),
        .take      (take),
        .cur_bits  (cur_bits),
        .cur_valid (cur_valid)
    );

    plsh_colour u_colour (
        .clk       (clk),
        .rst       (rst),
        .pix_en    (pix_en),
        .disp_en   (disp_en),
        .mode      (mode),
        .pal       (pal),
        .cur_bits  (cur_bits),
        .cur_valid (cur_valid),
        .rgb_q     (rgb_q),
        .mono_q    (mono)
    );

    assign red   = rgb_q.r;
    assign green = rgb_q.g;
    assign blue  = rgb_q.b;

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (ld_ready && !cur_valid)); // R10

endmodule

// File: tb/plane_shifter_test.sv
module plane_shifter_test;

    logic        clk;
    logic        rst;
    logic        pix_en;
    logic        disp_en;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [8:0]  wr_data;
    logic        ld_valid;
    logic [15:0] ld_data;
    logic        ld_ready;
    logic [2:0]  red;
    logic [2:0]  green;
    logic [2:0]  blue;
    logic        mono;

    int checks;
    int errors;

    plane_shifter uut (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .disp_en  (disp_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ld_valid (ld_valid),
        .ld_data  (ld_data),
        .ld_ready (ld_ready),
        .red      (red),
        .green    (green),
        .blue     (blue),
        .mono     (mono)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [8:0] pv(int i);
        return 9'((i * 37 + 5) % 512);
    endfunction

    task automatic chk(string tag, logic [9:0] got, logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [9:0] outs();
        return {red, green, blue, mono};
    endfunction

    task automatic write_reg(logic [4:0] a, logic [8:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_word(logic [15:0] d);
        ld_valid = 1'b1; ld_data = d;
        @(posedge clk); @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic pix_step();
        pix_en = 1'b1;
        @(posedge clk); @(negedge clk);
        pix_en = 1'b0;
    endtask

    task automatic load_group_a();
        load_word(16'hAAAA); load_word(16'hCCCC);
        load_word(16'hF0F0); load_word(16'hFF00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        checks = 0; errors = 0;
        rst = 1'b1; pix_en = 1'b0; disp_en = 1'b1; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; ld_valid = 1'b0; ld_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R11 reset outputs", outs(), 10'd0);
        chk("R11 reset ready", {9'd0, ld_ready}, 10'd1);

        // R1: program the palette
        for (int i = 0; i < 16; i++) write_reg(5'(i), pv(i));

        // R6: group fill in four-plane mode
        load_word(16'hAAAA); load_word(16'hCCCC); load_word(16'hF0F0);
        chk("R6 ready before last word", {9'd0, ld_ready}, 10'd1);
        load_word(16'hFF00);
        chk("R6 ready after last word", {9'd0, ld_ready}, 10'd0);

        // R8: empty shifter, first step only moves the group in
        pix_step();
        chk("R8 first step black", outs(), 10'd0);
        chk("R7 buffer freed", {9'd0, ld_ready}, 10'd1);

        load_word(16'h5555); load_word(16'h3333);
        load_word(16'h0F0F); load_word(16'h00FF);

        for (int b = 0; b < 16; b++) begin
            pix_step();
            chk($sformatf("R2 R5 pixel %0d", b), outs(), {pv(b), 1'b0});
        end
        chk("R7 buffer freed at handover", {9'd0, ld_ready}, 10'd1);
        for (int b = 0; b < 16; b++) begin
            pix_step();
            chk($sformatf("R7 second group pixel %0d", b), outs(), {pv(15 - b), 1'b0});
        end

        // R5: outputs hold while pix_en low
        repeat (3) @(negedge clk);
        chk("R5 hold", outs(), {pv(0), 1'b0});

        // R8: underrun
        pix_step();
        chk("R8 underrun black", outs(), 10'd0);

        // R9: blanking consumes pixels
        load_group_a();
        pix_step();
        disp_en = 1'b0;
        for (int b = 0; b < 4; b++) begin
            pix_step();
            chk($sformatf("R9 blank pixel %0d", b), outs(), 10'd0);
        end
        disp_en = 1'b1;
        for (int b = 4; b < 16; b++) begin
            pix_step();
            chk($sformatf("R9 resumed pixel %0d", b), outs(), {pv(b), 1'b0});
        end

        // R10: mode write flushes
        load_group_a();
        chk("R10 full before flush", {9'd0, ld_ready}, 10'd0);
        write_reg(5'd16, 9'd0);
        chk("R10 ready after flush", {9'd0, ld_ready}, 10'd1);
        pix_step();
        chk("R10 nothing pending", outs(), 10'd0);

        // R3: two-plane mode
        write_reg(5'd16, 9'd1);
        load_word(16'hAAAA);
        chk("R3 ready after one word", {9'd0, ld_ready}, 10'd1);
        load_word(16'hCCCC);
        chk("R6 R3 two-word group full", {9'd0, ld_ready}, 10'd0);
        pix_step();
        for (int b = 0; b < 16; b++) begin
            pix_step();
            chk($sformatf("R3 pixel %0d", b), outs(), {pv(b & 3), 1'b0});
        end

        // R4: one-plane mode, entry 0 bit 0 set -> inverted
        write_reg(5'd16, 9'd2);
        load_word(16'h1234);
        chk("R6 R4 one-word group full", {9'd0, ld_ready}, 10'd0);
        pix_step();
        for (int b = 0; b < 16; b++) begin
            pix_step();
            chk($sformatf("R4 inverted pixel %0d", b), outs(),
                {9'd0, ((16'h1234 >> b) & 16'd1) != 16'd0 ? 1'b0 : 1'b1});
        end

        // R4 R10: entry 0 bit 0 clear, mode value 3 acts as one-plane
        write_reg(5'd0, 9'h100);
        write_reg(5'd16, 9'd3);
        load_word(16'hA5C3);
        chk("R10 mode 3 one-word group", {9'd0, ld_ready}, 10'd0);
        pix_step();
        for (int b = 0; b < 16; b++) begin
            pix_step();
            chk($sformatf("R10 R4 normal pixel %0d", b), outs(),
                {9'd0, ((16'hA5C3 >> b) & 16'd1) != 16'd0 ? 1'b1 : 1'b0});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule